// File: doc/BRIEF.md
# Dual-Plane Self-Routing Banyan Fabric

An 8x8 bufferless cell switch made of two banyan planes, numbered 0 and 1, that are cross-connected at every stage. Each cell carries a priority bit, which also names its preferred plane, a 3-bit destination and a fixed-width payload that the switch never inspects. Stage `i` routes on destination bit `i`. At each stage every element can hand a cell to the next-stage element in its own plane or to the one with the same number in the other plane. A cell therefore moves around a failed middle-stage element, or around a lost contest for a link, and still crosses exactly log2N stages.

All cells move forward one stage per clock, in lockstep. A cell that cannot obtain a link to a healthy element is discarded. The discard is reported on a per-input pulse, together with the index of the stage where it happened. The pulse appears in the same cycle in which the cell would have reached its output, so every injected cell can be accounted for exactly once. The fault mask is static configuration. It is changed only while the fabric is empty.

Top module: `dpb_fabric`

## Requirements
- R1: While reset is low and in the first cycle after it, `out_valid` and `drop_pulse` are all zero.
- R2: A delivered cell leaves on the output whose index equals its destination field, and its payload is unchanged.
- R3: A cell presented with `in_valid` before clock edge E appears at its output after edge E+3 (log2N+1 edges) and at no other time.
- R4: Within a contest for one target line, priority-1 cells are served before priority-0 cells. Among cells of equal priority, plane 0 goes before plane 1, and within a plane the line with a 0 in the routed bit goes first. Each cell takes its preferred plane (its priority bit) if that plane's link is free and healthy. Otherwise it takes the other plane's link if that one is free and healthy, and if neither is available it is dropped.
- R5: A middle-stage element marked faulty never receives a cell. Traffic headed for it is diverted to the same-numbered element of the other plane.
- R6: When both planes' next-stage elements for a target line are faulty, every cell headed there is dropped, and the stage index reported is the stage the cell was leaving.
- R7: An output port delivers at most one cell per slot. The other cells bound for it in that slot are dropped with stage index 2.
- R8: `drop_pulse[s]` for the cell injected on input `s` rises in the same cycle in which that cell would have been delivered. `drop_stage` for that input is then the stage of the drop, and is 0 whenever no drop is reported.
- R9: Every injected cell is either delivered once or reported dropped once.
- R10: Fault mask bit `(j-1)*N + p*N/2 + e` marks element `e` of plane `p` in middle stage `j`. Element `e` is the line number with bit `j` removed.
- R11: When cells of different priority contend for one output, the priority-1 cell is delivered regardless of input index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 8 | One cell offered per input this slot |
| in_prio | input | 8 | Priority / preferred plane bit per input |
| in_dst | input | 24 | Destination per input, 3 bits each, input p at [3p+2:3p] |
| in_data | input | 128 | Payload per input, 16 bits each |
| fault_mask | input | 8 | Failed middle-stage elements, layout per R10 |
| out_valid | output | 8 | Cell delivered on this output |
| out_data | output | 128 | Payload per output, 16 bits each |
| drop_pulse | output | 8 | Cell from this input was discarded |
| drop_stage | output | 16 | Stage index of the discard, 2 bits per input |

## Verification
The bench targets the tie-break inside one contest. A design that ordered candidates differently would deliver the wrong one of two equal-priority cells bound for the same port, or let a low-priority cell displace a high-priority one. Fault cases place a failed element on one plane and then on both planes. A design that ignored the mask, or that decoded its bit layout wrongly, would deliver a cell that should have been lost or lose one that had a healthy detour. The drop report is checked every cycle against the delivery slot of the cell, so an off-by-one in the alignment pipeline or a stale stage index shows up as a mismatch. Random traffic under four fault patterns is compared against a bench model of the whole fabric.

// File: rtl/dpb_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the dual-plane banyan fabric.
// Assumes line numbers fit in an int.
package dpb_pkg;
    localparam int PLANES = 2;      // number of banyan planes
    localparam int GROUP  = 4;      // candidates per contest (2 lines x 2 planes)

    // Element number of a line at a stage: the line with bit j removed.
    function automatic int strip_bit(input int line, input int j);
        return ((line >> (j + 1)) << j) | (line & ((1 << j) - 1));
    endfunction
endpackage

// File: rtl/dpb_arb.sv
`timescale 1ns/1ps
// Module: dpb_arb
// Resolves one contest for a target line. Up to four candidates compete for
// two plane slots. High-priority candidates are served first, then index order.
// Each candidate tries its preferred plane, then the other one.
// Assumes slot_ok marks slots that lead to a healthy element.
module dpb_arb #(
    parameter int NC = dpb_pkg::GROUP
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NC-1:0] cand_v,
    input  logic [NC-1:0] cand_hi,
    input  logic [1:0]    slot_ok,
    output logic [NC-1:0] grant,
    output logic [NC-1:0] lane
);
    logic [1:0] taken;

    // Sequential-priority allocation of the two plane slots.
    always_comb begin
        taken = '0;
        grant = '0;
        lane  = '0;
        for (int ps = 0; ps < 2; ps++) begin
            for (int k = 0; k < NC; k++) begin
                if (cand_v[k] && (cand_hi[k] == (ps == 0))) begin
                    if (slot_ok[cand_hi[k]] && !taken[cand_hi[k]]) begin
                        grant[k] = 1'b1;
                        lane[k]  = cand_hi[k];
                        taken[cand_hi[k]] = 1'b1;
                    end else if (slot_ok[!cand_hi[k]] && !taken[!cand_hi[k]]) begin
                        grant[k] = 1'b1;
                        lane[k]  = !cand_hi[k];
                        taken[!cand_hi[k]] = 1'b1;
                    end
                end
            end
        end
    end

    // R4: each plane slot goes to at most one candidate
    a_r4_slot_unique_p0: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant & ~lane) <= 1);
    a_r4_slot_unique_p1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant & lane) <= 1);
    // R5: a granted slot always leads to a healthy element
    a_r5_healthy_p0: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~lane) != '0) |-> slot_ok[0]);
    a_r5_healthy_p1: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & lane) != '0) |-> slot_ok[1]);
    // R11: a low-priority grant never coexists with a losing high-priority cell
    a_r11_high_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~cand_hi) != '0) |-> ((cand_v & cand_hi & ~grant) == '0));
endmodule

// File: rtl/dpb_stage.sv
`timescale 1ns/1ps
// Module: dpb_stage
// One switching stage of both planes. For each target line it gathers the
// cells whose routed bit selects that line, arbitrates, and places winners in
// the chosen plane. Losers raise a drop flag indexed by source input.
// Assumes at most one cell per source input is present in the stage.
module dpb_stage #(
    parameter int N   = 8,
    parameter int LGN = 3,
    parameter int W   = 16,
    parameter int STG = 0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0][N-1:0]            i_v,
    input  logic [1:0][N-1:0]            i_pr,
    input  logic [1:0][N-1:0][LGN-1:0]   i_dst,
    input  logic [1:0][N-1:0][LGN-1:0]   i_src,
    input  logic [1:0][N-1:0][W-1:0]     i_dat,
    input  logic [1:0][N/2-1:0]          nxt_bad,
    output logic [1:0][N-1:0]            o_v,
    output logic [1:0][N-1:0]            o_pr,
    output logic [1:0][N-1:0][LGN-1:0]   o_dst,
    output logic [1:0][N-1:0][LGN-1:0]   o_src,
    output logic [1:0][N-1:0][W-1:0]     o_dat,
    output logic [N-1:0]                 drop
);
    localparam int  EW   = (N > 4) ? $clog2(N / 2) : 1;
    localparam bit  LAST = (STG == LGN - 1);
    localparam int  NC   = dpb_pkg::GROUP;

    logic [NC-1:0] cv_a    [N];
    logic [NC-1:0] hi_a    [N];
    logic [1:0]    ok_a    [N];
    logic [NC-1:0] grant_a [N];
    logic [NC-1:0] lane_a  [N];

    // Build the candidate set and healthy slots for each target line.
    always_comb begin
        logic [LGN-1:0] tl, ln;
        logic [EW-1:0]  e;
        logic           qb;
        for (int t = 0; t < N; t++) begin
            tl = LGN'(t);
            e  = EW'(dpb_pkg::strip_bit(t, STG + 1));
            for (int k = 0; k < NC; k++) begin
                qb = 1'(k >> 1);
                ln = tl;
                ln[STG] = k[0];
                cv_a[t][k] = i_v[qb][ln] && (i_dst[qb][ln][STG] == tl[STG]);
                hi_a[t][k] = i_pr[qb][ln];
            end
            if (LAST) ok_a[t] = 2'b01;
            else      ok_a[t] = ~{nxt_bad[1][e], nxt_bad[0][e]};
        end
    end

    // One arbiter per target line.
    for (genvar t = 0; t < N; t++) begin : g_line
        dpb_arb #(.NC(NC)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .cand_v  (cv_a[t]),
            .cand_hi (hi_a[t]),
            .slot_ok (ok_a[t]),
            .grant   (grant_a[t]),
            .lane    (lane_a[t])
        );
    end

    // Steer winners into their plane slot; flag losers by source input.
    always_comb begin
        logic [LGN-1:0] tl, ln;
        logic           qb;
        o_v = '0; o_pr = '0; o_dst = '0; o_src = '0; o_dat = '0; drop = '0;
        for (int t = 0; t < N; t++) begin
            tl = LGN'(t);
            for (int k = 0; k < NC; k++) begin
                qb = 1'(k >> 1);
                ln = tl;
                ln[STG] = k[0];
                if (grant_a[t][k]) begin
                    o_v  [lane_a[t][k]][tl] = 1'b1;
                    o_pr [lane_a[t][k]][tl] = i_pr[qb][ln];
                    o_dst[lane_a[t][k]][tl] = i_dst[qb][ln];
                    o_src[lane_a[t][k]][tl] = i_src[qb][ln];
                    o_dat[lane_a[t][k]][tl] = i_dat[qb][ln];
                end else if (cv_a[t][k]) begin
                    drop[i_src[qb][ln]] = 1'b1;
                end
            end
        end
    end

    // R9: every cell entering the stage leaves it or is dropped
    a_r9_conserve: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(i_v) == $countones(o_v) + $countones(drop));
endmodule

// File: rtl/dpb_fabric.sv
`timescale 1ns/1ps
// Module: dpb_fabric
// Top of the dual-plane banyan fabric. An input register is followed by log2N
// stages, each with its own register, so latency is log2N+1 cycles. A parallel
// pipeline carries drop flags so each is reported in its cell's delivery slot.
// Assumes N is a power of two of at least 8 and fault_mask is held steady
// while cells are in flight.
module dpb_fabric #(
    parameter int N   = 8,
    parameter int W   = 16,
    parameter int LGN = $clog2(N),
    parameter int FW  = (LGN - 2) * N,
    parameter int SW  = $clog2(LGN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     in_valid,
    input  logic [N-1:0]     in_prio,
    input  logic [N*LGN-1:0] in_dst,
    input  logic [N*W-1:0]   in_data,
    input  logic [FW-1:0]    fault_mask,
    output logic [N-1:0]     out_valid,
    output logic [N*W-1:0]   out_data,
    output logic [N-1:0]     drop_pulse,
    output logic [N*SW-1:0]  drop_stage
);
    logic [1:0][N-1:0]          pv   [LGN+1];
    logic [1:0][N-1:0]          pp   [LGN+1];
    logic [1:0][N-1:0][LGN-1:0] pd   [LGN+1];
    logic [1:0][N-1:0][LGN-1:0] ps   [LGN+1];
    logic [1:0][N-1:0][W-1:0]   pdat [LGN+1];

    logic [1:0][N-1:0]          sv   [LGN];
    logic [1:0][N-1:0]          sp   [LGN];
    logic [1:0][N-1:0][LGN-1:0] sd   [LGN];
    logic [1:0][N-1:0][LGN-1:0] ss   [LGN];
    logic [1:0][N-1:0][W-1:0]   sdat [LGN];
    logic [N-1:0]               sdrop[LGN];
    logic [1:0][N/2-1:0]        bad_w[LGN];

    logic [N-1:0]               dv   [LGN];
    logic [N-1:0][SW-1:0]       ds   [LGN];

    // Input register: every input enters plane 0 on its own line.
    always_ff @(posedge clk) begin
        if (!rst_n) pv[0] <= '0;
        else        pv[0] <= {{N{1'b0}}, in_valid};
        pp[0] <= '0; pd[0] <= '0; ps[0] <= '0; pdat[0] <= '0;
        for (int p = 0; p < N; p++) begin
            pp[0][0][p]   <= in_prio[p];
            pd[0][0][p]   <= in_dst[p*LGN +: LGN];
            ps[0][0][p]   <= LGN'(p);
            pdat[0][0][p] <= in_data[p*W +: W];
        end
    end

    for (genvar g = 0; g < LGN; g++) begin : g_stage
        // Fault view of the next stage: only middle stages can fail.
        if (g < LGN - 2) begin : g_mid
            assign bad_w[g] = fault_mask[g*N +: N];
        end else begin : g_edge
            assign bad_w[g] = '0;
        end

        dpb_stage #(.N(N), .LGN(LGN), .W(W), .STG(g)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .i_v     (pv[g]),
            .i_pr    (pp[g]),
            .i_dst   (pd[g]),
            .i_src   (ps[g]),
            .i_dat   (pdat[g]),
            .nxt_bad (bad_w[g]),
            .o_v     (sv[g]),
            .o_pr    (sp[g]),
            .o_dst   (sd[g]),
            .o_src   (ss[g]),
            .o_dat   (sdat[g]),
            .drop    (sdrop[g])
        );

        // Stage register: advance every cell one stage per clock.
        always_ff @(posedge clk) begin
            if (!rst_n) pv[g+1] <= '0;
            else        pv[g+1] <= sv[g];
            pp[g+1]   <= sp[g];
            pd[g+1]   <= sd[g];
            ps[g+1]   <= ss[g];
            pdat[g+1] <= sdat[g];
        end
    end

    // Drop pipeline: align each discard with its cell's delivery slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LGN; k++) begin
                dv[k] <= '0;
                ds[k] <= '0;
            end
        end else begin
            dv[0] <= sdrop[0];
            ds[0] <= '0;
            for (int k = 1; k < LGN; k++) begin
                dv[k] <= dv[k-1] | sdrop[k];
                for (int s = 0; s < N; s++)
                    ds[k][s] <= sdrop[k][s] ? SW'(k) : ds[k-1][s];
            end
        end
    end

    // Output flattening.
    always_comb begin
        out_valid  = pv[LGN][0];
        drop_pulse = dv[LGN-1];
        for (int t = 0; t < N; t++) begin
            out_data[t*W +: W]     = pdat[LGN][0][t];
            drop_stage[t*SW +: SW] = ds[LGN-1][t];
        end
    end

    for (genvar t = 0; t < N; t++) begin : g_chk
        // R2: a delivered cell sits on the port named by its destination
        a_r2_route: assert property (@(posedge clk) disable iff (!rst_n)
            pv[LGN][0][t] |-> (pd[LGN][0][t] == LGN'(t)));
        // R8: a reported stage index is always a real stage
        a_r8_stage_range: assert property (@(posedge clk) disable iff (!rst_n)
            drop_pulse[t] |-> (int'(drop_stage[t*SW +: SW]) < LGN));
        // R7: the last stage never leaves a cell in plane 1
        a_r7_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
            !sv[LGN-1][1][t]);
    end
endmodule

// File: tb/dpb_fabric_bench.sv
`timescale 1ns/1ps
module dpb_fabric_bench;
    localparam int N = 8, W = 16, LGN = 3, FW = 8, SW = 2, LAT = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     in_valid = '0;
    logic [N-1:0]     in_prio = '0;
    logic [N*LGN-1:0] in_dst = '0;
    logic [N*W-1:0]   in_data = '0;
    logic [FW-1:0]    fault_mask = '0;
    logic [N-1:0]     out_valid;
    logic [N*W-1:0]   out_data;
    logic [N-1:0]     drop_pulse;
    logic [N*SW-1:0]  drop_stage;

    dpb_fabric #(.N(N), .W(W)) u_dpb_fabric (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_prio(in_prio),
        .in_dst(in_dst), .in_data(in_data), .fault_mask(fault_mask),
        .out_valid(out_valid), .out_data(out_data),
        .drop_pulse(drop_pulse), .drop_stage(drop_stage)
    );

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0, errors = 0, cyc = 0;

    // current wave
    logic [N-1:0] w_v, w_pr;
    int           w_d   [N];
    logic [W-1:0] w_dat [N];

    // expectation ring, indexed by negedge count
    bit           e_live [8];
    logic [N-1:0] e_v    [8];
    logic [N-1:0] e_dp   [8];
    logic [W-1:0] e_dat  [8][N];
    int           e_ds   [8][N];
    string        e_lab  [8];

    function automatic int strip(input int x, input int j);
        return ((x >> (j + 1)) << j) | (x & ((1 << j) - 1));
    endfunction

    // Bench model of one injection wave through all stages.
    task automatic model(input int slot);
        int cv[2][N], cp[2][N], cd[2][N], cs[2][N];
        int nv[2][N], np[2][N], nd[2][N], ns[2][N];
        for (int q = 0; q < 2; q++) for (int p = 0; p < N; p++) begin
            cv[q][p] = (q == 0) ? int'(w_v[p]) : 0;
            cp[q][p] = int'(w_pr[p]); cd[q][p] = w_d[p]; cs[q][p] = p;
        end
        e_dp[slot] = '0;
        for (int p = 0; p < N; p++) e_ds[slot][p] = 0;
        for (int s = 0; s < LGN; s++) begin
            for (int q = 0; q < 2; q++) for (int p = 0; p < N; p++) begin
                nv[q][p] = 0; np[q][p] = 0; nd[q][p] = 0; ns[q][p] = 0;
            end
            for (int t = 0; t < N; t++) begin
                int ok[2], tk[2], la;
                la = t & ~(1 << s);
                tk[0] = 0; tk[1] = 0;
                if (s == LGN - 1) begin ok[0] = 1; ok[1] = 0; end
                else if (s + 1 <= LGN - 2) begin
                    for (int q = 0; q < 2; q++)
                        ok[q] = fault_mask[(s * 2 + q) * (N / 2) + strip(t, s + 1)] ? 0 : 1;
                end else begin ok[0] = 1; ok[1] = 1; end
                for (int pass = 0; pass < 2; pass++) for (int k = 0; k < 4; k++) begin
                    int q, l, pick;
                    q = k / 2; l = la | ((k % 2) << s);
                    if (cv[q][l] != 0 && ((cd[q][l] >> s) & 1) == ((t >> s) & 1)
                        && cp[q][l] == ((pass == 0) ? 1 : 0)) begin
                        pick = -1;
                        if (ok[cp[q][l]] != 0 && tk[cp[q][l]] == 0) pick = cp[q][l];
                        else if (ok[1 - cp[q][l]] != 0 && tk[1 - cp[q][l]] == 0) pick = 1 - cp[q][l];
                        if (pick < 0) begin
                            e_dp[slot][cs[q][l]] = 1'b1;
                            e_ds[slot][cs[q][l]] = s;
                        end else begin
                            tk[pick] = 1;
                            nv[pick][t] = 1; np[pick][t] = cp[q][l];
                            nd[pick][t] = cd[q][l]; ns[pick][t] = cs[q][l];
                        end
                    end
                end
            end
            cv = nv; cp = np; cd = nd; cs = ns;
        end
        for (int t = 0; t < N; t++) begin
            e_v[slot][t] = (cv[0][t] != 0);
            e_dat[slot][t] = (cv[0][t] != 0) ? w_dat[cs[0][t]] : '0;
        end
    endtask

    task automatic check_slot(input int slot);
        string lab;
        lab = e_lab[slot];
        checks++;
        if (out_valid !== e_v[slot]) begin
            errors++;
            $display("FAIL %s (R3) out_valid actual=%b expected=%b", lab, out_valid, e_v[slot]);
        end
        if (e_v[slot] != '0) begin
            checks++;
            for (int t = 0; t < N; t++)
                if (e_v[slot][t] && out_data[t*W +: W] !== e_dat[slot][t]) begin
                    errors++;
                    $display("FAIL %s (R2) port %0d data actual=%h expected=%h",
                             lab, t, out_data[t*W +: W], e_dat[slot][t]);
                end
        end
        checks++;
        if (drop_pulse !== e_dp[slot]) begin
            errors++;
            $display("FAIL %s (R9) drop_pulse actual=%b expected=%b", lab, drop_pulse, e_dp[slot]);
        end
        checks++;
        for (int s = 0; s < N; s++)
            if (int'(drop_stage[s*SW +: SW]) != e_ds[slot][s]) begin
                errors++;
                $display("FAIL %s (R8) input %0d drop_stage actual=%0d expected=%0d",
                         lab, s, drop_stage[s*SW +: SW], e_ds[slot][s]);
            end
    endtask

    // One slot: check what is due, then offer the current wave.
    task automatic step(input string lab);
        int ns;
        @(negedge clk);
        if (e_live[cyc % 8]) check_slot(cyc % 8);
        e_live[cyc % 8] = 1'b0;
        in_valid = w_v; in_prio = w_pr;
        for (int p = 0; p < N; p++) begin
            in_dst[p*LGN +: LGN] = LGN'(w_d[p]);
            in_data[p*W +: W]    = w_dat[p];
        end
        ns = (cyc + LAT) % 8;
        model(ns);
        e_lab[ns] = lab;
        e_live[ns] = 1'b1;
        cyc++;
    endtask

    task automatic clear_wave();
        w_v = '0; w_pr = '0;
        for (int p = 0; p < N; p++) begin w_d[p] = 0; w_dat[p] = '0; end
    endtask

    task automatic put(input int src, input int dst, input bit hi);
        w_v[src] = 1'b1; w_pr[src] = hi; w_d[src] = dst;
        w_dat[src] = W'(16'hA000 + src * 16 + dst);
    endtask

    task automatic idle(input int n, input string lab);
        for (int i = 0; i < n; i++) begin clear_wave(); step(lab); end
    endtask

    initial begin : watchdog
        #(4 * 100000);
        errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) e_live[i] = 1'b0;
        clear_wave();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== '0 || drop_pulse !== '0) begin
            errors++;
            $display("FAIL R1 reset outputs actual=%b/%b expected=0/0", out_valid, drop_pulse);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== '0 || drop_pulse !== '0) begin
            errors++;
            $display("FAIL R1 post-reset outputs actual=%b/%b expected=0/0", out_valid, drop_pulse);
        end

        // R2 / R3: lone cell, fault free
        clear_wave(); put(5, 2, 1'b0); step("R2");
        idle(5, "R3");
        // R2: full permutation, no contention
        clear_wave();
        for (int p = 0; p < N; p++) put(p, (p * 3 + 1) % N, p[0]);
        step("R2"); idle(5, "R3");
        // R4: equal priority, same output: input 2 wins over input 6
        clear_wave(); put(2, 4, 1'b0); put(6, 4, 1'b0); step("R4");
        idle(5, "R7");
        // R11: high priority on a higher input wins the output
        clear_wave(); put(0, 3, 1'b0); put(7, 3, 1'b1); step("R11");
        idle(5, "R11");
        // R7: three cells to one output
        clear_wave(); put(1, 5, 1'b0); put(3, 5, 1'b0); put(4, 5, 1'b1); step("R7");
        idle(5, "R7");
        // R5 / R10: plane-0 element 0 of stage 1 failed -> detour
        fault_mask = 8'h01;
        clear_wave(); put(1, 6, 1'b0); step("R5");
        clear_wave(); put(0, 2, 1'b0); put(1, 4, 1'b0); step("R10");
        idle(5, "R5");
        // R6: both planes' element 0 failed -> drop at stage 0
        fault_mask = 8'h11;
        clear_wave(); put(1, 6, 1'b0); put(3, 7, 1'b0); step("R6");
        idle(5, "R6");
        // R6: whole middle stage failed
        fault_mask = 8'hFF;
        clear_wave(); for (int p = 0; p < N; p++) put(p, 7 - p, 1'b0); step("R6");
        idle(5, "R6");

        // Random traffic under several fault patterns
        for (int m = 0; m < 4; m++) begin
            case (m)
                0: fault_mask = 8'h00;
                1: fault_mask = 8'h24;
                2: fault_mask = 8'h5A;
                default: fault_mask = 8'h81;
            endcase
            for (int i = 0; i < 150; i++) begin
                clear_wave();
                for (int p = 0; p < N; p++)
                    if ($urandom_range(9, 0) < 6) begin
                        w_v[p] = 1'b1;
                        w_pr[p] = ($urandom_range(3, 0) == 0);
                        w_d[p] = int'($urandom_range(N - 1, 0));
                        w_dat[p] = W'($urandom);
                    end
                step("R9");
            end
            idle(5, "R9");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule